// File: doc/BRIEF.md
# 16-bit Lookahead Arithmetic/Logic Unit

This block is a purely combinational 16-bit ALU. A 3-bit operation select chooses the function. Four functions are shifts and rotates, and the other four are addition and three bitwise logic functions. Each operand can be bitwise complemented on its way in. Together with the adder's carry input, this gives subtraction and other derived operations without spending extra opcodes.

The adder is a two-level carry-lookahead structure. Each 4-bit group forms its internal carries from generate and propagate terms. It also hands a group generate and a group propagate to a second lookahead level, and that level produces the carry into every group.

Shifts take operand A (after optional inversion) as the value and the low four bits of operand B (after optional inversion) as the distance. Besides the result, the block drives an overflow flag and a zero flag. The overflow flag is judged as signed or unsigned according to a mode input.

Top module: `lookahead_alu`

## Requirements
- R1: opSel 000 rotates left, 001 shifts left filling with zeros, 010 rotates right, and 011 shifts right copying bit 15. The value is the effective A and the distance is bits [3:0] of the effective B.
- R2: opSel 100 gives result = effective A + effective B + carryIn, modulo 2^16.
- R3: opSel 101 gives effective A OR effective B, 110 gives XOR, and 111 gives AND.
- R4: The effective A is ~opA when invertA is 1 and opA otherwise. The effective B is ~opB when invertB is 1 and opB otherwise. This applies to every operation, shifts included.
- R5: With opSel 100, invertB = 1 and carryIn = 1, result equals opA − opB modulo 2^16.
- R6: With opSel 100 and signedMode = 1, overflow is 1 exactly when both effective operands have equal bit 15 and result bit 15 differs from it.
- R7: With opSel 100 and signedMode = 0, overflow equals the carry out of bit 15 of the addition.
- R8: overflow is 0 for every opSel other than 100.
- R9: zeroFlag is 1 exactly when all 16 result bits are 0.
- R10: signedMode has no effect on result for any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand; value for shifts |
| opB | input | 16 | Second operand; bits [3:0] are the shift distance |
| carryIn | input | 1 | Carry into the adder's least significant bit |
| opSel | input | 3 | Operation select |
| invertA | input | 1 | Complement operand A before use |
| invertB | input | 1 | Complement operand B before use |
| signedMode | input | 1 | 1: overflow judged as two's complement; 0: as unsigned |
| result | output | 16 | Operation result |
| overflow | output | 1 | Addition overflow under the selected mode |
| zeroFlag | output | 1 | Result is all zeros |

## Verification
The assertions check the following on every input change: the zero flag against the result, the absence of overflow outside addition, the sum and the signed and unsigned overflow of the addition, and the AND function, each against the ports. Only the bench's scenarios show the following: the four shift and rotate modes at every distance, inversion applied to the shift operands, subtraction through inversion plus carry, and the independence of the result from signedMode. The bench sweeps every combination of opcode, inversions, mode and carry over boundary and pseudo-random operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ROL = 3'b000,
    OP_SLL = 3'b001,
    OP_ROR = 3'b010,
    OP_SRA = 3'b011,
    OP_ADD = 3'b100,
    OP_OR  = 3'b101,
    OP_XOR = 3'b110,
    OP_AND = 3'b111
  } aluOp_e;

  typedef enum logic [1:0] {
    SH_ROL = 2'b00,
    SH_SLL = 2'b01,
    SH_ROR = 2'b10,
    SH_SRA = 2'b11
  } shiftMode_e;

  typedef struct packed {
    logic       addEn;
    logic       orEn;
    logic       xorEn;
    logic       andEn;
    logic       shiftEn;
    shiftMode_e shiftMode;
  } aluStrobes_t;

endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GROUP = 4
) (
  input  logic [GROUP-1:0] a,
  input  logic [GROUP-1:0] b,
  input  logic             cin,
  output logic [GROUP-1:0] sum,
  output logic             grpGen,
  output logic             grpProp
);
  logic [GROUP-1:0] gen;
  logic [GROUP-1:0] prop;
  logic [GROUP-1:0] carry;

  assign gen  = a & b;
  assign prop = a ^ b;

  // each carry formed directly from generate/propagate terms (no ripple)
  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      logic term;
      logic acc;
      term = cin;
      for (int j = 0; j < i; j++) term = term & prop[j];
      acc = term;
      for (int k = 0; k < i; k++) begin
        logic t;
        t = gen[k];
        for (int j = k + 1; j < i; j++) t = t & prop[j];
        acc = acc | t;
      end
      carry[i] = acc;
    end
  end

  always_comb begin
    grpProp = &prop;
    grpGen  = 1'b0;
    for (int k = 0; k < GROUP; k++) begin
      logic t;
      t = gen[k];
      for (int j = k + 1; j < GROUP; j++) t = t & prop[j];
      grpGen = grpGen | t;
    end
  end

  assign sum = prop ^ carry;
endmodule

// File: rtl/cla_adder.sv
module cla_adder #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NGRP = WIDTH / GROUP;

  logic [NGRP-1:0] grpGen;
  logic [NGRP-1:0] grpProp;
  logic [NGRP:0]   grpCarry;

  // second lookahead level over the group generate/propagate pairs
  always_comb begin
    for (int i = 0; i <= NGRP; i++) begin
      logic acc;
      logic term;
      term = cin;
      for (int j = 0; j < i; j++) term = term & grpProp[j];
      acc = term;
      for (int k = 0; k < i; k++) begin
        logic t;
        t = grpGen[k];
        for (int j = k + 1; j < i; j++) t = t & grpProp[j];
        acc = acc | t;
      end
      grpCarry[i] = acc;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : gGroup
    cla_group #(.GROUP(GROUP)) uGroup (
      .a      (a[g*GROUP +: GROUP]),
      .b      (b[g*GROUP +: GROUP]),
      .cin    (grpCarry[g]),
      .sum    (sum[g*GROUP +: GROUP]),
      .grpGen (grpGen[g]),
      .grpProp(grpProp[g])
    );
  end

  assign cout = grpCarry[NGRP];
endmodule

// File: rtl/barrel_shifter.sv
module barrel_shifter
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  localparam int AMTW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] value,
  input  logic [AMTW-1:0]  amount,
  input  shiftMode_e       mode,
  output logic [WIDTH-1:0] shifted
);
  always_comb begin
    logic [WIDTH-1:0] v;
    v = value;
    for (int s = 0; s < AMTW; s++) begin
      if (amount[s]) begin
        unique case (mode)
          SH_ROL: v = (v << (1 << s)) | (v >> (WIDTH - (1 << s)));
          SH_SLL: v = v << (1 << s);
          SH_ROR: v = (v >> (1 << s)) | (v << (WIDTH - (1 << s)));
          SH_SRA: v = WIDTH'($signed(v) >>> (1 << s));
          default: v = v;
        endcase
      end
    end
    shifted = v;
  end
endmodule

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [2:0]  opSel,
  output aluStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    strobes.shiftMode = shiftMode_e'(opSel[1:0]);
    unique case (aluOp_e'(opSel))
      OP_ADD: strobes.addEn = 1'b1;
      OP_OR:  strobes.orEn  = 1'b1;
      OP_XOR: strobes.xorEn = 1'b1;
      OP_AND: strobes.andEn = 1'b1;
      default: strobes.shiftEn = 1'b1;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4,
  localparam int AMTW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic             invertA,
  input  logic             invertB,
  input  logic             signedMode,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic             zeroFlag
);
  logic [WIDTH-1:0] effA;
  logic [WIDTH-1:0] effB;
  logic [WIDTH-1:0] sumVal;
  logic             carryOut;
  logic [WIDTH-1:0] shiftVal;
  logic             signedOvf;

  assign effA = invertA ? ~opA : opA;
  assign effB = invertB ? ~opB : opB;

  cla_adder #(.WIDTH(WIDTH), .GROUP(GROUP)) uAdder (
    .a   (effA),
    .b   (effB),
    .cin (carryIn),
    .sum (sumVal),
    .cout(carryOut)
  );

  barrel_shifter #(.WIDTH(WIDTH)) uShift (
    .value  (effA),
    .amount (effB[AMTW-1:0]),
    .mode   (strobes.shiftMode),
    .shifted(shiftVal)
  );

  always_comb begin
    result = '0;
    if (strobes.addEn)   result = sumVal;
    if (strobes.orEn)    result = effA | effB;
    if (strobes.xorEn)   result = effA ^ effB;
    if (strobes.andEn)   result = effA & effB;
    if (strobes.shiftEn) result = shiftVal;
  end

  assign signedOvf = (effA[WIDTH-1] == effB[WIDTH-1]) && (sumVal[WIDTH-1] != effA[WIDTH-1]);
  assign overflow  = strobes.addEn & (signedMode ? signedOvf : carryOut);
  assign zeroFlag  = ~|result;
endmodule

// File: rtl/lookahead_alu.sv
module lookahead_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [2:0]       opSel,
  input  logic             invertA,
  input  logic             invertB,
  input  logic             signedMode,
  output logic [WIDTH-1:0] result,
  output logic             overflow,
  output logic             zeroFlag
);
  aluStrobes_t strobes;

  alu_decode uDecode (
    .opSel  (opSel),
    .strobes(strobes)
  );

  alu_datapath #(.WIDTH(WIDTH), .GROUP(GROUP)) uPath (
    .opA       (opA),
    .opB       (opB),
    .carryIn   (carryIn),
    .invertA   (invertA),
    .invertB   (invertB),
    .signedMode(signedMode),
    .strobes   (strobes),
    .result    (result),
    .overflow  (overflow),
    .zeroFlag  (zeroFlag)
  );
endmodule

// File: rtl/lookahead_alu_checker.sv
module lookahead_alu_checker #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             carryIn,
  input logic [2:0]       opSel,
  input logic             invertA,
  input logic             invertB,
  input logic             signedMode,
  input logic [WIDTH-1:0] result,
  input logic             overflow,
  input logic             zeroFlag
);
  logic [WIDTH-1:0] chkA;
  logic [WIDTH-1:0] chkB;
  logic [WIDTH:0]   wideSum;
  logic             known;

  assign chkA    = invertA ? ~opA : opA;
  assign chkB    = invertB ? ~opB : opB;
  assign wideSum = {1'b0, chkA} + {1'b0, chkB} + {{WIDTH{1'b0}}, carryIn};
  assign known   = !$isunknown({opA, opB, carryIn, opSel, invertA, invertB, signedMode,
                                result, overflow, zeroFlag});

  always_comb begin
    if (known) begin
      a_r9_zero_flag: assert (zeroFlag == (result == '0))
        else $error("zero flag mismatch");
      a_r8_no_overflow: assert (opSel == 3'b100 || !overflow)
        else $error("overflow outside addition");
      a_r2_add_sum: assert (opSel != 3'b100 || result == wideSum[WIDTH-1:0])
        else $error("sum mismatch");
      a_r7_unsigned_overflow: assert (opSel != 3'b100 || signedMode || overflow == wideSum[WIDTH])
        else $error("unsigned overflow mismatch");
      a_r6_signed_overflow: assert (opSel != 3'b100 || !signedMode ||
          overflow == ((chkA[WIDTH-1] == chkB[WIDTH-1]) && (result[WIDTH-1] != chkA[WIDTH-1])))
        else $error("signed overflow mismatch");
      a_r3_and_function: assert (opSel != 3'b111 || result == (chkA & chkB))
        else $error("and mismatch");
    end
  end
endmodule

bind lookahead_alu lookahead_alu_checker #(.WIDTH(WIDTH)) uChecker (
  .opA       (opA),
  .opB       (opB),
  .carryIn   (carryIn),
  .opSel     (opSel),
  .invertA   (invertA),
  .invertB   (invertB),
  .signedMode(signedMode),
  .result    (result),
  .overflow  (overflow),
  .zeroFlag  (zeroFlag)
);

// File: tb/test_lookahead_alu.sv
module test_lookahead_alu;
  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [2:0]  opSel = '0;
  logic        invertA = 1'b0;
  logic        invertB = 1'b0;
  logic        signedMode = 1'b0;
  logic [15:0] result;
  logic        overflow;
  logic        zeroFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  lookahead_alu i_lookahead_alu (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opSel(opSel),
    .invertA(invertA), .invertB(invertB), .signedMode(signedMode),
    .result(result), .overflow(overflow), .zeroFlag(zeroFlag)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (op=%b iA=%b iB=%b s=%b c=%b A=%h B=%h)",
               tag, act, exp, opSel, invertA, invertB, signedMode, carryIn, opA, opB);
    end
  endtask

  // independent reference from the requirements
  task automatic model(output logic [15:0] expRes, output logic expOvf);
    logic [15:0] a, b;
    logic [16:0] s;
    int n;
    a = invertA ? ~opA : opA;
    b = invertB ? ~opB : opB;
    n = int'(b[3:0]);
    s = {1'b0, a} + {1'b0, b} + {16'd0, carryIn};
    expOvf = 1'b0;
    case (opSel)
      3'd0: expRes = 16'((32'(a) << n) | (32'(a) >> (16 - n)));
      3'd1: expRes = 16'(32'(a) << n);
      3'd2: expRes = 16'((32'(a) >> n) | (32'(a) << (16 - n)));
      3'd3: expRes = 16'($signed(a) >>> n);
      3'd4: begin
        expRes = s[15:0];
        expOvf = signedMode ? ((a[15] == b[15]) && (s[15] != a[15])) : s[16];
      end
      3'd5: expRes = a | b;
      3'd6: expRes = a ^ b;
      default: expRes = a & b;
    endcase
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] expRes;
    logic expOvf;
    string rTag, oTag;
    @(posedge clk);
    opA = a;
    opB = b;
    @(negedge clk);
    model(expRes, expOvf);
    rTag = (opSel < 3'd4) ? "R1" : (opSel == 3'd4) ? "R2" : "R3";
    if (invertA || invertB) rTag = {rTag, "/R4"};
    oTag = (opSel != 3'd4) ? "R8" : (signedMode ? "R6" : "R7");
    check(rTag, result, expRes);
    check(oTag, {15'd0, overflow}, {15'd0, expOvf});
    check("R9", {15'd0, zeroFlag}, {15'd0, expRes == 16'd0});
  endtask

  function automatic logic [15:0] corner(input int i);
    case (i % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h8000;
      3: return 16'h7FFF;
      4: return 16'h0001;
      default: return 16'h5A3C;
    endcase
  endfunction

  task automatic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r0, r1;
    // idle state with all-zero inputs: rotate-left of zero
    @(negedge clk);
    check("R9", {15'd0, zeroFlag}, 16'd1);
    check("R8", {15'd0, overflow}, 16'd0);
    check("R1", result, 16'd0);

    // full sweep of every control combination
    for (int ctl = 0; ctl < 128; ctl++) begin
      opSel      = 3'(ctl);
      invertA    = ctl[3];
      invertB    = ctl[4];
      signedMode = ctl[5];
      carryIn    = ctl[6];
      for (int i = 0; i < 36; i++) apply(corner(i), corner(i / 6));
      for (int i = 0; i < 16; i++) begin
        logic [15:0] ra;
        nextRand(); ra = lfsr;
        nextRand();
        apply(ra, {lfsr[15:4], 4'(i)});
      end
    end

    // R5: subtraction via inverted B plus carry
    opSel = 3'd4; invertA = 1'b0; invertB = 1'b1; carryIn = 1'b1; signedMode = 1'b1;
    for (int i = 0; i < 40; i++) begin
      nextRand(); r0 = lfsr; nextRand(); r1 = lfsr;
      @(posedge clk); opA = r0; opB = r1;
      @(negedge clk);
      check("R5", result, r0 - r1);
    end

    // R10: signedMode leaves result unchanged
    for (int op = 0; op < 8; op++) begin
      opSel = 3'(op); invertB = 1'b0; carryIn = 1'b0;
      for (int i = 0; i < 6; i++) begin
        nextRand();
        @(posedge clk); opA = lfsr; opB = {lfsr[7:0], lfsr[15:8]}; signedMode = 1'b0;
        @(negedge clk); r0 = result;
        @(posedge clk); signedMode = 1'b1;
        @(negedge clk); r1 = result;
        check("R10", r1, r0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule